// File: doc/BRIEF.md
# Serial Configuration EEPROM Command Controller

This block sits between a host register pair and a three-wire serial EEPROM that stores 16-bit configuration words. The host writes one command word that holds both a two-bit operation code and a six-bit word address. The controller then builds the serial frame, shifts it out on a divided serial clock, and for a read it shifts the 16 data bits back in. For erase and write it closes the frame and then reopens chip select to wait for the device's ready indication. Word data goes through a separate data register. The host loads that register before a write and reads the result from it after a read.

A single busy flag is the host's only completion indication. It reads as bit 15 of the command register and stays high from the cycle after an accepted command until chip select has dropped at the end of the operation. While busy is high, writes to either register are ignored. Software therefore polls busy between the steps of a write sequence: write-enable, erase, write-enable again, then write. For erase and write, busy also covers the device programming time, and a timeout ends the wait if the device never reports ready. The serial data input is synchronised into the clock domain, so the serial clock divider must be at least one more than the number of synchroniser stages.

Top module: `eeprom_cmd_ctl`

## Requirements
- R1: After reset, busy, chip select, serial clock and the data register output are all 0.
- R2: A command register write is accepted only when busy is low, and busy reads 1 in the next cycle. A command write while busy is high starts no serial frame and changes nothing.
- R3: Command bits [7:6] choose the operation: 10 read, 01 write, 11 erase, 00 command-only (address bits 11xxxx mean write-enable). Bits [5:0] are the word address and bits [15:8] are ignored. The frame sends a start bit of 1, then the operation code, then the address, each MSB first.
- R4: Chip select and the serial clock are low whenever busy is low. Each serial clock half period lasts CLK_DIV system clocks. The serial data output does not change while the serial clock is high.
- R5: A read shifts in 16 bits, MSB first, each sampled on a rising serial clock edge. The word appears on the data register output before busy clears. A read lasts exactly 51*CLK_DIV cycles of busy and a command-only operation lasts 19*CLK_DIV.
- R6: A write sends the 16-bit data register value, MSB first, after the address. The value used is the one held when the command was accepted.
- R7: After an erase or write frame, chip select drops for one half period and then rises again. Busy stays high until the serial data input reads high.
- R8: If the serial data input never reads high after an erase or write, busy clears after TIMEOUT_TICKS half periods of polling. The whole write lasts (52+TIMEOUT_TICKS)*CLK_DIV cycles.
- R9: A data register write while busy is low updates the data output on the next cycle. A data register write while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWe | input | 1 | Command register write strobe |
| cmdWrData | input | 16 | Command word: [7:6] operation, [5:0] address |
| dataWe | input | 1 | Data register write strobe |
| dataWrData | input | 16 | Word to load into the data register |
| busy | output | 1 | Operation in progress (command register bit 15) |
| dataOut | output | 16 | Data register contents |
| eeCs | output | 1 | EEPROM chip select |
| eeSk | output | 1 | EEPROM serial clock |
| eeDi | output | 1 | Serial data toward the EEPROM |
| eeDo | input | 1 | Serial data and ready status from the EEPROM |

## Verification
Two collisions matter here: a new command write landing in the final busy cycle of the previous operation, and a data register write landing in the cycle where a read completes and loads the data register. The bench holds the command strobe high for the whole tail of a write-enable. It then expects exactly one more frame, started on the first cycle in which busy is low, with busy low for a single cycle in between. It also holds the data strobe high across a read. It expects the read word on the output in the first idle cycle and the host value only one cycle later. A behavioural EEPROM decodes every frame from the pins, and a per-clock monitor times each serial clock half period.

// File: rtl/eectl_pkg.sv
package eectl_pkg;

  // operation codes carried in the command word and in the serial frame
  typedef enum logic [1:0] {
    OP_MISC  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } eeOp_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HEAD,
    S_RDATA,
    S_WDATA,
    S_GAP,
    S_POLL,
    S_DONE
  } eeState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic divRun;
    logic load;
    logic shiftTx;
    logic sampleRx;
    logic loadRx;
    logic clrTimer;
    logic incTimer;
  } eeStrobe_t;

endpackage

// File: rtl/eectl_datapath.sv
module eectl_datapath
  import eectl_pkg::*;
#(
  parameter int CLK_DIV       = 8,
  parameter int TIMEOUT_TICKS = 4096,
  parameter int SYNC_STAGES   = 2,
  parameter int ADDR_W        = 6,
  parameter int DATA_W        = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  eeStrobe_t         strb,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostData,
  input  logic              eeDo,
  output logic              tick,
  output logic              timeoutHit,
  output logic              doSync,
  output logic              eeDi,
  output logic [DATA_W-1:0] dataOut
);

  localparam int FRAME_W = 3 + ADDR_W + DATA_W;
  localparam int TMR_W   = $clog2(TIMEOUT_TICKS + 1);

  logic [FRAME_W-1:0] txShift;
  logic [DATA_W-1:0]  rxShift;
  logic [DATA_W-1:0]  dataReg;
  logic [TMR_W-1:0]   timer;

  // serial clock half-period divider
  generate
    if (CLK_DIV <= 1) begin : g_noDiv
      assign tick = strb.divRun;
    end else begin : g_div
      localparam int DIV_W = $clog2(CLK_DIV);
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rstN || !strb.divRun) begin
          divCnt <= '0;
        end else if (tick) begin
          divCnt <= '0;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
      assign tick = strb.divRun && (divCnt == DIV_W'(CLK_DIV - 1));
    end
  endgenerate

  // synchroniser for the EEPROM output pin
  generate
    if (SYNC_STAGES == 0) begin : g_noSync
      assign doSync = eeDo;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] syncQ;
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
          always_ff @(posedge clk) begin
            if (!rstN) syncQ[0] <= 1'b0;
            else       syncQ[0] <= eeDo;
          end
        end else begin : g_next
          always_ff @(posedge clk) begin
            if (!rstN) syncQ[g] <= 1'b0;
            else       syncQ[g] <= syncQ[g-1];
          end
        end
      end
      assign doSync = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  // outgoing frame: start bit, opcode, address, data word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strb.load) begin
      txShift <= {1'b1, cmdOp, cmdAddr, dataReg};
    end else if (strb.shiftTx) begin
      txShift <= {txShift[FRAME_W-2:0], 1'b0};
    end
  end
  assign eeDi = txShift[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (strb.sampleRx) begin
      rxShift <= {rxShift[DATA_W-2:0], doSync};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (strb.loadRx) begin
      dataReg <= rxShift;
    end else if (hostWr) begin
      dataReg <= hostData;
    end
  end
  assign dataOut = dataReg;

  // ready-poll timeout, counted in half periods
  always_ff @(posedge clk) begin
    if (!rstN || strb.clrTimer) begin
      timer <= '0;
    end else if (strb.incTimer) begin
      timer <= timer + 1'b1;
    end
  end
  assign timeoutHit = (timer == TMR_W'(TIMEOUT_TICKS - 1));

endmodule

// File: rtl/eectl_control.sv
module eectl_control
  import eectl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdAccept,
  input  logic [1:0] cmdOp,
  input  logic       tick,
  input  logic       timeoutHit,
  input  logic       doSync,
  output eeStrobe_t  strb,
  output logic       eeCs,
  output logic       eeSk,
  output logic       busy
);

  localparam int HEAD_BITS = 3 + ADDR_W;
  localparam int MAX_BITS  = (HEAD_BITS > DATA_W) ? HEAD_BITS : DATA_W;
  localparam int CNT_W     = $clog2(MAX_BITS + 1);

  eeState_e   state;
  eeOp_e      opReg;
  logic       ph;
  logic [CNT_W-1:0] bitsLeft;
  logic       lastBit;
  logic       shifting;

  assign lastBit  = (bitsLeft == CNT_W'(1));
  assign shifting = (state == S_HEAD) || (state == S_RDATA) || (state == S_WDATA);
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      opReg    <= OP_MISC;
      ph       <= 1'b0;
      bitsLeft <= '0;
      eeCs     <= 1'b0;
      eeSk     <= 1'b0;
    end else if (cmdAccept) begin
      state    <= S_HEAD;
      opReg    <= eeOp_e'(cmdOp);
      ph       <= 1'b0;
      bitsLeft <= CNT_W'(HEAD_BITS);
      eeCs     <= 1'b1;
      eeSk     <= 1'b0;
    end else if (tick) begin
      unique case (state)
        S_HEAD, S_RDATA, S_WDATA: begin
          if (!ph) begin
            eeSk <= 1'b1;
            ph   <= 1'b1;
          end else begin
            eeSk <= 1'b0;
            ph   <= 1'b0;
            if (!lastBit) begin
              bitsLeft <= bitsLeft - 1'b1;
            end else if (state == S_HEAD) begin
              unique case (opReg)
                OP_READ: begin
                  state    <= S_RDATA;
                  bitsLeft <= CNT_W'(DATA_W);
                end
                OP_WRITE: begin
                  state    <= S_WDATA;
                  bitsLeft <= CNT_W'(DATA_W);
                end
                OP_ERASE: begin
                  state <= S_GAP;
                  eeCs  <= 1'b0;
                end
                default: begin
                  state <= S_DONE;
                  eeCs  <= 1'b0;
                end
              endcase
            end else if (state == S_RDATA) begin
              state <= S_DONE;
              eeCs  <= 1'b0;
            end else begin
              state <= S_GAP;
              eeCs  <= 1'b0;
            end
          end
        end
        S_GAP: begin
          eeCs  <= 1'b1;
          state <= S_POLL;
        end
        S_POLL: begin
          if (doSync || timeoutHit) begin
            state <= S_DONE;
            eeCs  <= 1'b0;
          end
        end
        default: begin
          state <= S_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.divRun   = busy;
    strb.load     = cmdAccept;
    strb.shiftTx  = tick && ph && shifting;
    strb.sampleRx = tick && !ph && (state == S_RDATA);
    strb.loadRx   = tick && ph && (state == S_RDATA) && lastBit;
    strb.clrTimer = (state == S_GAP);
    strb.incTimer = tick && (state == S_POLL) && !doSync;
  end

endmodule

// File: rtl/eeprom_cmd_ctl.sv
module eeprom_cmd_ctl
  import eectl_pkg::*;
#(
  parameter int CLK_DIV       = 8,
  parameter int TIMEOUT_TICKS = 4096,
  parameter int SYNC_STAGES   = 2,
  parameter int ADDR_W        = 6,
  parameter int DATA_W        = 16,
  parameter int REG_W         = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWe,
  input  logic [REG_W-1:0]  cmdWrData,
  input  logic              dataWe,
  input  logic [DATA_W-1:0] dataWrData,
  output logic              busy,
  output logic [DATA_W-1:0] dataOut,
  output logic              eeCs,
  output logic              eeSk,
  output logic              eeDi,
  input  logic              eeDo
);

  eeStrobe_t strb;
  logic      cmdAccept;
  logic      hostWr;
  logic      tick;
  logic      timeoutHit;
  logic      doSync;
  logic [1:0]        cmdOp;
  logic [ADDR_W-1:0] cmdAddr;
  logic      unusedHigh;

  assign cmdAccept  = cmdWe && !busy;
  assign hostWr     = dataWe && !busy;
  assign cmdOp      = cmdWrData[ADDR_W+1:ADDR_W];
  assign cmdAddr    = cmdWrData[ADDR_W-1:0];
  assign unusedHigh = ^cmdWrData[REG_W-1:ADDR_W+2];

  eectl_control #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdAccept (cmdAccept),
    .cmdOp     (cmdOp),
    .tick      (tick),
    .timeoutHit(timeoutHit),
    .doSync    (doSync),
    .strb      (strb),
    .eeCs      (eeCs),
    .eeSk      (eeSk),
    .busy      (busy)
  );

  eectl_datapath #(
    .CLK_DIV      (CLK_DIV),
    .TIMEOUT_TICKS(TIMEOUT_TICKS),
    .SYNC_STAGES  (SYNC_STAGES),
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmdOp     (cmdOp),
    .cmdAddr   (cmdAddr),
    .hostWr    (hostWr),
    .hostData  (dataWrData),
    .eeDo      (eeDo),
    .tick      (tick),
    .timeoutHit(timeoutHit),
    .doSync    (doSync),
    .eeDi      (eeDi),
    .dataOut   (dataOut)
  );

endmodule

// File: rtl/eectl_checker.sv
module eectl_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdWe,
  input logic              busy,
  input logic [DATA_W-1:0] dataOut,
  input logic              eeCs,
  input logic              eeSk,
  input logic              eeDi
);

  a_r4_idle_pins: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!eeCs && !eeSk));

  a_r4_sk_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    !eeCs |-> !eeSk);

  a_r4_di_hold: assert property (@(posedge clk) disable iff (!rstN)
    (eeSk && $past(eeSk)) |-> $stable(eeDi));

  a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWe && !busy) |=> busy);

  a_r9_data_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !eeCs) |=> $stable(dataOut));

endmodule

bind eeprom_cmd_ctl eectl_checker #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .cmdWe  (cmdWe),
  .busy   (busy),
  .dataOut(dataOut),
  .eeCs   (eeCs),
  .eeSk   (eeSk),
  .eeDi   (eeDi)
);

// File: tb/eeprom_cmd_ctl_test.sv
module eeprom_cmd_ctl_test;

  localparam int CLK_DIV  = 4;
  localparam int TMO      = 128;
  localparam int PROG_CYC = 300;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWe = 1'b0;
  logic [15:0] cmdWrData = '0;
  logic        dataWe = 1'b0;
  logic [15:0] dataWrData = '0;
  logic        busy;
  logic [15:0] dataOut;
  logic        eeCs, eeSk, eeDi;
  logic        eeDo = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  eeprom_cmd_ctl #(.CLK_DIV(CLK_DIV), .TIMEOUT_TICKS(TMO)) uut (
    .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdWrData(cmdWrData),
    .dataWe(dataWe), .dataWrData(dataWrData), .busy(busy), .dataOut(dataOut),
    .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi), .eeDo(eeDo)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural serial EEPROM
  logic [15:0] mem [64];
  logic [23:0] shReg;
  logic [1:0]  mOp;
  logic [5:0]  mAddr;
  int  nBits = 0, rdIdx = 0, frames = 0, progLeft = 0;
  bit  started = 0, wen = 0, pollMode = 0, stuck = 0;
  logic prevSk = 1'b0, prevCs = 1'b0;

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h0101) ^ 16'h0F0F;
    mem[2] = 16'hBEEF;
  end

  always @(negedge clk) begin
    if (progLeft > 0) progLeft--;
    if (!eeCs) begin
      if (prevCs) begin
        if (pollMode) pollMode = 0;
        else if (started && wen && mOp == 2'b11 && nBits == 8) begin
          mem[mAddr] = 16'hFFFF; progLeft = PROG_CYC; pollMode = 1;
        end else if (started && wen && mOp == 2'b01 && nBits == 24) begin
          mem[mAddr] = shReg[15:0]; progLeft = PROG_CYC; pollMode = 1;
        end
      end
      started = 0; nBits = 0; rdIdx = 0; eeDo = 1'b0;
    end else begin
      if (eeSk && !prevSk) begin
        if (!started) begin
          if (eeDi) begin started = 1; nBits = 0; end
        end else if (nBits < 8 || (mOp == 2'b01 && nBits < 24)) begin
          shReg = {shReg[22:0], eeDi};
          nBits++;
          if (nBits == 8) begin
            mOp = shReg[7:6]; mAddr = shReg[5:0]; frames++;
            if (mOp == 2'b00 && shReg[5:4] == 2'b11) wen = 1;
            if (mOp == 2'b00 && shReg[5:4] == 2'b00) wen = 0;
          end
        end
      end
      if (!eeSk && prevSk && started && nBits == 8 && mOp == 2'b10 && rdIdx < 16) begin
        eeDo = mem[mAddr][4'(15 - rdIdx)];
        rdIdx++;
      end
      if (pollMode) eeDo = (progLeft == 0) && !stuck;
    end
    prevSk = eeSk; prevCs = eeCs;
  end

  // per-clock pin monitor
  logic monSk = 1'b0, monCs = 1'b0, monDi = 1'b0;
  int runLen = 0;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (!busy) chk(!eeCs && !eeSk, "R4 idle pins", {eeCs, eeSk}, 0);
      if (eeCs && !monCs) runLen = 1;
      else if (eeSk != monSk) begin
        chk(runLen == CLK_DIV, "R4 half period", runLen, CLK_DIV);
        runLen = 1;
      end else runLen++;
      if (eeSk && monSk) chk(eeDi == monDi, "R4 data hold", eeDi, monDi);
    end
    monSk = eeSk; monCs = eeCs; monDi = eeDi;
  end

  task automatic wrData(input logic [15:0] v);
    @(negedge clk); dataWe = 1'b1; dataWrData = v;
    @(negedge clk); dataWe = 1'b0;
  endtask

  task automatic startCmd(input logic [15:0] v);
    @(negedge clk); cmdWe = 1'b1; cmdWrData = v;
    @(negedge clk); cmdWe = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", busy, 1);
  endtask

  task automatic waitIdle(output int dur);
    dur = 1;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (!busy) break;
      dur++;
    end
  endtask

  task automatic runOp(input logic [15:0] v, output int dur);
    startCmd(v);
    waitIdle(dur);
  endtask

  initial begin
    int dur, f0;
    repeat (5) @(negedge clk);
    chk(busy == 0 && eeCs == 0 && eeSk == 0 && dataOut == 0, "R1 reset",
        {busy, eeCs, eeSk, dataOut}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && dataOut == 0, "R1 after release", {busy, dataOut}, 0);

    wrData(16'hA5C3);
    chk(dataOut == 16'hA5C3, "R9 idle data write", dataOut, 16'hA5C3);

    f0 = frames;
    runOp(16'h0030, dur);
    chk(frames == f0 + 1 && mOp == 2'b00 && mAddr == 6'h30 && wen, "R3 write-enable frame",
        {mOp, mAddr}, 8'h30);
    chk(dur == 19 * CLK_DIV, "R5 command-only duration", dur, 19 * CLK_DIV);

    runOp(16'h00C5, dur);
    chk(mem[5] == 16'hFFFF, "R3 erase", mem[5], 16'hFFFF);
    chk(dur > PROG_CYC && dur < TMO * CLK_DIV, "R7 erase busy window", dur, PROG_CYC);

    runOp(16'h0030, dur);
    wrData(16'h1234);
    runOp(16'h0045, dur);
    chk(mem[5] == 16'h1234, "R6 write data", mem[5], 16'h1234);
    chk(dur > PROG_CYC && dur < TMO * CLK_DIV, "R7 write busy window", dur, PROG_CYC);

    runOp(16'hFF85, dur);
    chk(dataOut == 16'h1234, "R5 read back, R3 upper bits ignored", dataOut, 16'h1234);
    chk(dur == 51 * CLK_DIV, "R5 read duration", dur, 51 * CLK_DIV);

    runOp(16'h0080, dur);
    chk(dataOut == 16'h0F0F, "R5 read addr 0", dataOut, 16'h0F0F);

    runOp(16'h0030, dur);
    wrData(16'h8001);
    runOp(16'h007F, dur);
    runOp(16'h00BF, dur);
    chk(dataOut == 16'h8001, "R6 write then R5 read addr 63", dataOut, 16'h8001);

    // command while busy is ignored
    f0 = frames;
    startCmd(16'h0081);
    repeat (10) @(negedge clk);
    cmdWe = 1'b1; cmdWrData = 16'h00C1;
    @(negedge clk); cmdWe = 1'b0;
    waitIdle(dur);
    chk(frames == f0 + 1, "R2 busy command ignored", frames, f0 + 1);
    chk(dataOut == mem[1] && mem[1] != 16'hFFFF, "R2 no erase", dataOut, mem[1]);

    // data write held across a read completion
    startCmd(16'h0082);
    dataWe = 1'b1; dataWrData = 16'h1111;
    waitIdle(dur);
    chk(dataOut == 16'hBEEF, "R9 busy data write ignored", dataOut, 16'hBEEF);
    @(negedge clk); dataWe = 1'b0;
    chk(dataOut == 16'h1111, "R9 first idle write", dataOut, 16'h1111);

    // data write during a write operation must not alter the sent word
    runOp(16'h0030, dur);
    wrData(16'h5A5A);
    startCmd(16'h004A);
    dataWe = 1'b1; dataWrData = 16'h0000;
    repeat (20) @(negedge clk);
    dataWe = 1'b0;
    waitIdle(dur);
    chk(mem[10] == 16'h5A5A, "R6 word captured at accept", mem[10], 16'h5A5A);
    chk(dataOut == 16'h5A5A, "R9 data reg unchanged", dataOut, 16'h5A5A);

    // command held through the tail of a write-enable
    f0 = frames;
    startCmd(16'h0030);
    cmdWe = 1'b1; cmdWrData = 16'h0082;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (!busy) break;
    end
    chk(busy == 1'b0, "R2 idle gap", busy, 0);
    @(negedge clk); cmdWe = 1'b0;
    chk(busy == 1'b1, "R2 accept on first idle cycle", busy, 1);
    waitIdle(dur);
    chk(frames == f0 + 2, "R2 exactly two frames", frames, f0 + 2);
    chk(dataOut == 16'hBEEF, "R5 back-to-back read", dataOut, 16'hBEEF);

    // ready never reported
    stuck = 1;
    runOp(16'h0030, dur);
    wrData(16'h7777);
    runOp(16'h0047, dur);
    chk(dur >= (52 + TMO) * CLK_DIV - 2 && dur <= (52 + TMO) * CLK_DIV + CLK_DIV,
        "R8 timeout duration", dur, (52 + TMO) * CLK_DIV);
    stuck = 0;
    @(negedge clk);
    chk(!busy && !eeCs, "R8 released", {busy, eeCs}, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    finished = 1;
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule